// File: doc/BRIEF.md
# Reference-Clock Frequency Lock Detector

This block decides whether a recovered clock, already divided down by sixteen, runs at the same frequency as a low-speed reference clock. It sits beside a clock-and-data-recovery loop whose oscillator is meant to run at sixteen times the reference. Its single output is an alarm, `lol`, that the surrounding system reads as "the recovery loop is not frequency locked".

Time is cut into measurement windows of N = 2^WIN_LOG2 reference cycles. During each window the block counts rising edges of the divided recovered clock. The count crosses into the reference domain as a Gray code through a two-flop synchronizer. At the end of each window the block compares the count with N. A count that differs from N by more than TOL edges is a bad window. With the defaults (N = 8192, TOL = 8) this is a mismatch of about 1000 ppm, in either direction. The alarm is a registered output driven by a four-state machine and changes only when a window closes.

The states and transitions are as follows. PRIME is the state after reset. Its window only sets the first snapshot, and its close always moves to ALARM. ALARM moves to PEND on a good window and stays in ALARM on a bad one. PEND moves to LOCK on a good window and falls back to ALARM on a bad one. LOCK stays in LOCK on a good window and moves to ALARM on a bad one. `lol` is 0 only in LOCK.

Top module: `freq_lock_monitor`

## Requirements
- R1: While `rst_n` is low, `lol` is 1. It stays 1 after release until the state machine first reaches LOCK.
- R2: Counting the first rising `ref_clk` edge after `rst_n` goes high as edge 1, window verdicts are made at edges 2 + k·N (k ≥ 1). `lol` changes at no other edge.
- R3: The first window after reset gives no verdict. At its close `lol` stays 1, whatever the recovered clock did.
- R4: A window in which the number of `rec_clk` rising edges exceeds N + TOL, or falls below N − TOL, sets `lol` to 1 at that verdict edge. This holds for a fast clock and for a slow clock.
- R5: `lol` falls to 0 only at the close of the second consecutive in-tolerance window. A single good window after a bad one leaves it at 1.
- R6: A recovered clock with no edges for a whole window sets `lol` to 1 at that window's verdict.
- R7: Once `lol` is 0, each in-tolerance window keeps it at 0.
- R8: A window whose count lies within N ± TOL is in tolerance. A clock offset of about ±500 ppm therefore counts as good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Low-speed reference clock; the measurement window is timed in its cycles |
| rec_clk | input | 1 | Recovered full-rate clock after division by sixteen |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| lol | output | 1 | Loss-of-lock alarm, 1 = not locked, synchronous to ref_clk |

## Verification
The hardest state to reach from the ports is the PEND-to-ALARM fall-back, where one good window is followed by a bad one. The output looks the same as staying in ALARM, so this path only shows when two good windows come later and the alarm clears one window later than it otherwise would. The bench sets the period of `rec_clk` separately for each window and switches it right after each verdict edge. This gives exact good–bad–good–good runs, including a stalled clock and offsets of ±2000 ppm and ±500 ppm. A behavioural model counts edges and predicts the alarm for every reference cycle.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_ALARM = 2'd1,
        ST_PEND  = 2'd2,
        ST_LOCK  = 2'd3
    } lock_state_t;

endpackage

// File: rtl/flm_rec_counter.sv
`timescale 1ns/1ps
// Edge counter in the recovered-clock domain, published as a Gray code so
// that only one bit moves per edge when crossing into the reference domain.
module flm_rec_counter #(
    parameter int CNT_W = 15
) (
    input  logic             rec_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_q
);

    logic             rst_meta_q;
    logic             rst_rec_q;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    always_ff @(posedge rec_clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_meta_q <= 1'b0;
            rst_rec_q  <= 1'b0;
        end else begin
            rst_meta_q <= 1'b1;
            rst_rec_q  <= rst_meta_q;
        end
    end

    assign bin_nxt = bin_q + CNT_W'(1);

    always_ff @(posedge rec_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (rst_rec_q) begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

endmodule

// File: rtl/flm_gray_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a Gray-coded count, followed by conversion
// back to binary in the reference domain.
module flm_gray_sync #(
    parameter int CNT_W  = 15,
    parameter int STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_ref_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);

    logic [CNT_W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge ref_clk or negedge rst_ref_n) begin
                if (!rst_ref_n) stage_q[s] <= '0;
                else            stage_q[s] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge ref_clk or negedge rst_ref_n) begin
                if (!rst_ref_n) stage_q[s] <= '0;
                else            stage_q[s] <= stage_q[s-1];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            bin_out[i] = ^(stage_q[STAGES-1] >> i);
        end
    end

endmodule

// File: rtl/flm_window_timer.sv
`timescale 1ns/1ps
// Free-running window timer: one-cycle end marker every 2^WIN_LOG2 cycles.
module flm_window_timer #(
    parameter int WIN_LOG2 = 13
) (
    input  logic ref_clk,
    input  logic rst_ref_n,
    output logic win_end
);

    logic [WIN_LOG2-1:0] tick_q;

    always_ff @(posedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n) tick_q <= '0;
        else            tick_q <= tick_q + WIN_LOG2'(1);
    end

    assign win_end = &tick_q;

endmodule

// File: rtl/flm_judge.sv
`timescale 1ns/1ps
// Takes a snapshot of the synchronized count at each window close and
// judges the edges seen in that window against N +/- TOL.
module flm_judge #(
    parameter int WIN_LOG2 = 13,
    parameter int CNT_W    = 15,
    parameter int TOL      = 8
) (
    input  logic             ref_clk,
    input  logic             rst_ref_n,
    input  logic             win_end,
    input  logic [CNT_W-1:0] count_bin,
    output logic             win_good
);

    localparam int unsigned NOMINAL = 1 << WIN_LOG2;

    logic [CNT_W-1:0]      snap_q;
    logic [CNT_W-1:0]      delta;
    logic signed [CNT_W:0] err;

    always_ff @(posedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n)   snap_q <= '0;
        else if (win_end) snap_q <= count_bin;
    end

    assign delta = count_bin - snap_q;
    assign err   = $signed({1'b0, delta}) - $signed((CNT_W+1)'(NOMINAL));

    assign win_good = (err <= $signed((CNT_W+1)'(TOL))) &&
                      (err >= -$signed((CNT_W+1)'(TOL)));

endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ns/1ps
module freq_lock_monitor
    import flm_pkg::*;
#(
    parameter int WIN_LOG2    = 13,
    parameter int TOL         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    output logic lol
);

    localparam int CNT_W = WIN_LOG2 + 2;

    logic             rst_meta_q;
    logic             rst_ref_n;
    logic [CNT_W-1:0] rec_gray;
    logic [CNT_W-1:0] rec_bin;
    logic             win_end;
    logic             win_good;
    lock_state_t      state_q;
    lock_state_t      state_nxt;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_meta_q <= 1'b0;
            rst_ref_n  <= 1'b0;
        end else begin
            rst_meta_q <= 1'b1;
            rst_ref_n  <= rst_meta_q;
        end
    end

    flm_rec_counter #(.CNT_W(CNT_W)) rec_cnt_i (
        .rec_clk (rec_clk),
        .rst_n   (rst_n),
        .gray_q  (rec_gray)
    );

    flm_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) sync_i (
        .ref_clk   (ref_clk),
        .rst_ref_n (rst_ref_n),
        .gray_in   (rec_gray),
        .bin_out   (rec_bin)
    );

    flm_window_timer #(.WIN_LOG2(WIN_LOG2)) timer_i (
        .ref_clk   (ref_clk),
        .rst_ref_n (rst_ref_n),
        .win_end   (win_end)
    );

    flm_judge #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .TOL(TOL)) judge_i (
        .ref_clk   (ref_clk),
        .rst_ref_n (rst_ref_n),
        .win_end   (win_end),
        .count_bin (rec_bin),
        .win_good  (win_good)
    );

    always_comb begin
        state_nxt = state_q;
        if (win_end) begin
            unique case (state_q)
                ST_PRIME: state_nxt = ST_ALARM;
                ST_ALARM: state_nxt = win_good ? ST_PEND : ST_ALARM;
                ST_PEND:  state_nxt = win_good ? ST_LOCK : ST_ALARM;
                ST_LOCK:  state_nxt = win_good ? ST_LOCK : ST_ALARM;
                default:  state_nxt = ST_ALARM;
            endcase
        end
    end

    always_ff @(posedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n) state_q <= ST_PRIME;
        else            state_q <= state_nxt;
    end

    always_ff @(posedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n) lol <= 1'b1;
        else            lol <= (state_nxt != ST_LOCK);
    end

endmodule

// File: rtl/freq_lock_monitor_chk.sv
`timescale 1ns/1ps
module freq_lock_monitor_chk (
    input logic ref_clk,
    input logic rst_ref_n,
    input logic win_end,
    input logic win_good,
    input logic priming,
    input logic lol
);

    logic [1:0] ok_run;

    always_ff @(posedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n)              ok_run <= 2'd0;
        else if (win_end) begin
            if (priming || !win_good) ok_run <= 2'd0;
            else if (ok_run != 2'd3)  ok_run <= ok_run + 2'd1;
        end
    end

    assert_quiet_between_verdicts_R2: assert property (
        @(posedge ref_clk) disable iff (!rst_ref_n)
        !win_end |=> $stable(lol));

    assert_prime_keeps_alarm_R3: assert property (
        @(posedge ref_clk) disable iff (!rst_ref_n)
        (win_end && priming) |=> lol);

    assert_bad_window_alarms_R4: assert property (
        @(posedge ref_clk) disable iff (!rst_ref_n)
        (win_end && !priming && !win_good) |=> lol);

    assert_clear_needs_two_good_R5: assert property (
        @(posedge ref_clk) disable iff (!rst_ref_n)
        $fell(lol) |-> (ok_run >= 2'd2));

    assert_lock_holds_R7: assert property (
        @(posedge ref_clk) disable iff (!rst_ref_n)
        (!lol && win_end && win_good) |=> !lol);

endmodule

bind freq_lock_monitor freq_lock_monitor_chk chk_i (
    .ref_clk   (ref_clk),
    .rst_ref_n (rst_ref_n),
    .win_end   (win_end),
    .win_good  (win_good),
    .priming   (state_q == flm_pkg::ST_PRIME),
    .lol       (lol)
);

// File: tb/freq_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module freq_lock_monitor_tb_top;

    localparam int WL = 12;
    localparam int N  = 1 << WL;
    localparam int TL = 4;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic lol;

    real   rec_half = 10.0;
    bit    rec_stop = 1'b0;
    string cur_tag  = "R3";
    string last_tag = "R3";

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int ref_edges = 0;
    int rec_edges = 0;
    int last_rec  = 0;
    int win_idx   = 0;
    int good_run  = 0;
    bit exp_lol   = 1'b1;
    bit verdict_now = 1'b0;

    freq_lock_monitor #(.WIN_LOG2(WL), .TOL(TL)) dut_i (
        .ref_clk (ref_clk),
        .rec_clk (rec_clk),
        .rst_n   (rst_n),
        .lol     (lol)
    );

    always #10.0 ref_clk = ~ref_clk;

    always begin
        if (rec_stop) begin
            rec_clk = 1'b0;
            @(negedge rec_stop);
        end else begin
            #(rec_half) rec_clk = ~rec_clk;
        end
    end

    // Behavioural model: edge counts, window verdicts, two-good-window clear.
    always @(posedge rec_clk) if (rst_n) rec_edges++;

    always @(posedge ref_clk) begin
        verdict_now = 1'b0;
        if (rst_n) begin
            ref_edges++;
            if (ref_edges > 2 && ((ref_edges - 2) % N) == 0) begin
                int d;
                d = rec_edges - last_rec - N;
                last_rec = rec_edges;
                last_tag = cur_tag;
                verdict_now = 1'b1;
                win_idx++;
                if (win_idx > 1) begin
                    if (d <= TL && d >= -TL) begin
                        good_run++;
                        if (good_run >= 2) exp_lol = 1'b0;
                    end else begin
                        good_run = 0;
                        exp_lol  = 1'b1;
                    end
                end
            end
        end
    end

    always @(negedge ref_clk) begin
        if (!done) begin
            string tag;
            if (!rst_n)           tag = "R1";
            else if (verdict_now) tag = last_tag;
            else                  tag = "R2";
            checks++;
            if (lol !== exp_lol) begin
                errors++;
                $display("FAIL %s: lol=%b expected=%b (window %0d, edge %0d)",
                         tag, lol, exp_lol, win_idx, ref_edges);
            end
        end
    end

    task automatic run_window(input real half, input bit stop, input string tag);
        int w;
        rec_half = half;
        rec_stop = stop;
        cur_tag  = tag;
        w = win_idx;
        wait (win_idx == w + 1);
    endtask

    initial begin
        repeat (5) @(negedge ref_clk);
        rst_n = 1'b1;
        run_window(10.0,   1'b0, "R3");   // prime window, alarm held
        run_window(10.0,   1'b0, "R5");   // first good, still alarmed
        run_window(10.0,   1'b0, "R5");   // second good, clears
        run_window(9.995,  1'b0, "R8");   // +500 ppm, in tolerance
        run_window(9.980,  1'b0, "R4");   // +2000 ppm, fast, alarm
        run_window(10.0,   1'b0, "R5");   // one good: pending
        run_window(9.980,  1'b0, "R4");   // bad from pending
        run_window(10.0,   1'b0, "R5");
        run_window(10.0,   1'b0, "R5");   // clears
        run_window(10.020, 1'b0, "R4");   // -2000 ppm, slow, alarm
        run_window(10.005, 1'b0, "R8");   // -500 ppm counts as good
        run_window(10.0,   1'b0, "R5");   // clears
        run_window(10.0,   1'b1, "R6");   // stalled recovered clock
        run_window(10.0,   1'b0, "R5");
        run_window(10.0,   1'b0, "R5");
        run_window(10.0,   1'b0, "R7");   // lock held
        run_window(9.995,  1'b0, "R7");   // lock held at +500 ppm
        repeat (3) @(negedge ref_clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, window=%0d expected=17", win_idx);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule